// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block sequences whole-array copies between a volatile working array and a nonvolatile shadow array. A store copies working data into the shadow. A recall clears the working array and then reloads it from the shadow. A store can be requested in three ways: a software command, an external agent pulling the shared busy line low, or a falling supply-good indication. A recall is requested by a software command, or it is latched while the supply is low and runs by itself once the supply comes back.

Stores requested by hardware, meaning the busy line or a supply drop, are skipped when no write has been accepted since the last store or recall. A software store always runs. One open-drain line serves two purposes: other agents pull it low to request a store, and the block pulls it low while it is busy. The line is modelled as a sensed level plus separate drive-low and drive-high enables.

Working-array reads and writes are gated while an operation runs, during a lockout after it, while the supply is low, and while the line is held low. All durations are clock-cycle counts set by parameters. The shadow array is a simple behavioural model.

Top module: `nvs_ctrl`

## Requirements
- R1: While access is open (idle state, line high, supply good, no pending recall), `acc_ok` follows `acc_req`. A write updates the addressed word, and a read returns that word on `acc_rdata` one cycle later. A read that is not accepted returns zero.
- R2: The line sampled low while the array is dirty starts a hardware store. It runs T_DLY cycles in the grace state (code 1), then T_ST cycles in the store state (code 2). At the end of the store the working array is copied into the shadow.
- R3: A store requested through the line or by a supply drop does not run when no write has been accepted since the last store or recall. A software store always runs, going straight to the store state with no grace cycles.
- R4: `busy_drv_lo` is high in every cycle of the grace, store and recall states and in no other cycle. After a store, `busy_drv_hi` is high for exactly T_HI cycles (release state, code 3). After a recall it is not asserted at all.
- R5: The release state (after a store) or the recall state is followed by T_LZ lockout cycles (code 4) with `acc_ok` low. `op_done` pulses for exactly one cycle per store or recall.
- R6: While the line is held low by another agent and the array is clean, the block does not drive the line, does not store, and keeps `acc_ok` low.
- R7: A recall request is latched while `supply_ok` is low, including after reset. It starts when the supply is good, holds the recall state (code 5) for T_RCL cycles, and is followed by lockout.
- R8: After a recall, every working word equals its shadow value. The shadow array is not modified by a recall.
- R9: A falling `supply_ok` while the array is dirty and auto-store is enabled starts a store with grace, just like R2. While auto-store is disabled, a supply drop starts nothing.
- R10: The auto-store flag comes out of reset enabled. `sw_auto_wr` sets it to `sw_auto_val` while access is open. The new value survives a recall only if a store ran after the change; otherwise the recall restores the stored value.
- R11: While `supply_ok` is low, `acc_ok` stays low.
- R12: When a recall start and a store request come in the same cycle, the recall runs and the store request is dropped.
- R13: A completed store or recall clears the dirty state, so a following request through the line starts no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Working-array access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Word address |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Read data, one cycle after an accepted read; zero otherwise |
| acc_ok | output | 1 | Access accepted this cycle |
| sw_store | input | 1 | Software store request (one cycle) |
| sw_recall | input | 1 | Software recall request (one cycle) |
| sw_auto_wr | input | 1 | Write the auto-store enable flag |
| sw_auto_val | input | 1 | Value for the auto-store flag |
| supply_ok | input | 1 | Supply above the switch threshold |
| busy_pin_i | input | 1 | Sensed level of the shared open-drain busy line |
| busy_drv_lo | output | 1 | Pull the busy line low |
| busy_drv_hi | output | 1 | Actively drive the busy line high |
| op_done | output | 1 | One-cycle pulse when a store or recall completes |
| op_state | output | 3 | 0 idle, 1 grace, 2 store, 3 release, 4 lockout, 5 recall |

## Verification
A dirty flag stuck low would surface as a missing hardware store the first time the line or the supply falls after a write. That shows as `op_state` staying at 0 and, after the next recall, as stale read data. A wrong cycle counter shows at once as state durations or drive-enable counts that differ from the parameters within a single operation. A lost recall latch or a wrong auto-store flag shows up one supply cycle later as read data that does not match the last value that was stored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DELAY   = 3'd1,
        ST_STORE   = 3'd2,
        ST_RELEASE = 3'd3,
        ST_LOCKOUT = 3'd4,
        ST_RECALL  = 3'd5
    } nvs_state_e;

    // Array transfer commands issued by the sequencer
    typedef struct packed {
        logic copy;   // working -> shadow
        logic clear;  // zero the working array (recall step one)
        logic load;   // shadow -> working (recall step two)
    } nvs_xfer_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int unsigned T_DLY = 4,
    parameter int unsigned T_ST  = 64,
    parameter int unsigned T_HI  = 4,
    parameter int unsigned T_LZ  = 8,
    parameter int unsigned T_RCL = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_store,
    input  logic       sw_recall,
    input  logic       supply_ok,
    input  logic       pin_i,
    input  logic       wr_acc,
    input  logic       auto_en,
    output nvs_state_e st,
    output nvs_xfer_t  xfer,
    output logic       drv_lo,
    output logic       drv_hi,
    output logic       done,
    output logic       access_ok
);
    localparam int unsigned TMAX =
        max_u(max_u(max_u(T_DLY, T_ST), max_u(T_HI, T_LZ)), T_RCL);
    localparam int unsigned CW = $clog2(TMAX + 1);

    nvs_state_e    st_q, nxt;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          dirty_q, pend_q, supply_q, done_q;
    logic          last, supply_fall, pend_start;

    function automatic logic [CW-1:0] dur_of(input nvs_state_e s);
        case (s)
            ST_DELAY:   return CW'(T_DLY - 1);
            ST_STORE:   return CW'(T_ST - 1);
            ST_RELEASE: return CW'(T_HI - 1);
            ST_LOCKOUT: return CW'(T_LZ - 1);
            ST_RECALL:  return CW'(T_RCL - 1);
            default:    return '0;
        endcase
    endfunction

    assign last        = (cnt_q == '0);
    assign supply_fall = supply_q & ~supply_ok;
    assign pend_start  = (st_q == ST_IDLE) && pend_q && supply_ok;

    always_comb begin
        nxt  = st_q;
        xfer = '0;
        case (st_q)
            ST_IDLE: begin
                // The latched recall is tested first: recall wins a same-cycle collision
                if (pend_start) begin
                    nxt        = ST_RECALL;
                    xfer.clear = 1'b1;
                end else if (!supply_ok) begin
                    if (supply_fall && dirty_q && auto_en) nxt = ST_DELAY;
                end else if (sw_recall) begin
                    nxt        = ST_RECALL;
                    xfer.clear = 1'b1;
                end else if (sw_store) begin
                    nxt = ST_STORE;
                end else if (!pin_i && dirty_q) begin
                    nxt = ST_DELAY;
                end
            end
            ST_DELAY:   if (last) nxt = ST_STORE;
            ST_STORE:   if (last) begin nxt = ST_RELEASE; xfer.copy = 1'b1; end
            ST_RELEASE: if (last) nxt = ST_LOCKOUT;
            ST_LOCKOUT: if (last) nxt = ST_IDLE;
            ST_RECALL:  if (last) begin nxt = ST_LOCKOUT; xfer.load = 1'b1; end
            default:    nxt = ST_IDLE;
        endcase
        if (nxt != st_q)     cnt_d = dur_of(nxt);
        else if (!last)      cnt_d = cnt_q - 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            dirty_q  <= 1'b0;
            pend_q   <= 1'b1;
            supply_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            st_q     <= nxt;
            cnt_q    <= cnt_d;
            supply_q <= supply_ok;
            done_q   <= xfer.copy | xfer.load;
            if (!supply_ok)      pend_q <= 1'b1;
            else if (pend_start) pend_q <= 1'b0;
            if (xfer.copy || xfer.load) dirty_q <= 1'b0;
            else if (wr_acc)            dirty_q <= 1'b1;
        end
    end

    assign st        = st_q;
    assign done      = done_q;
    assign drv_lo    = (st_q == ST_DELAY) || (st_q == ST_STORE) || (st_q == ST_RECALL);
    assign drv_hi    = (st_q == ST_RELEASE);
    assign access_ok = (st_q == ST_IDLE) && pin_i && supply_ok && !pend_q && !sw_recall;

    // R1: an accepted write leaves the array dirty
    a_r1_dirty_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> dirty_q);
    // R3: a clean array never enters the grace state
    a_r3_clean_no_hw_store: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !dirty_q) |=> (st_q != ST_DELAY));
    // R5: access stays closed right after the line is released
    a_r5_lockout_blocks: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_hi) |-> !access_ok);
    // R12: a latched recall starts ahead of any store request
    a_r12_recall_wins: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && pend_q && supply_ok) |=> (st_q == ST_RECALL));
endmodule

// File: rtl/nvs_mem.sv
module nvs_mem
    import nvs_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  nvs_xfer_t     xfer,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          auto_wr,
    input  logic          auto_val,
    output logic [DW-1:0] rdata,
    output logic          auto_en
);
    logic [DW-1:0] work_q [DEPTH];
    logic [DW-1:0] sh_q   [DEPTH];
    logic          auto_q, auto_sh;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                work_q[i] <= '0;
                sh_q[i]   <= '0;
            end
            auto_q  <= 1'b1;
            auto_sh <= 1'b1;
            rdata_q <= '0;
        end else begin
            if (xfer.copy) begin
                for (int i = 0; i < DEPTH; i++) sh_q[i] <= work_q[i];
                auto_sh <= auto_q;
            end
            if (xfer.clear) begin
                for (int i = 0; i < DEPTH; i++) work_q[i] <= '0;
            end else if (xfer.load) begin
                for (int i = 0; i < DEPTH; i++) work_q[i] <= sh_q[i];
                auto_q <= auto_sh;
            end else begin
                if (wr_en)   work_q[addr] <= wdata;
                if (auto_wr) auto_q       <= auto_val;
            end
            rdata_q <= rd_en ? work_q[addr] : '0;
        end
    end

    assign rdata   = rdata_q;
    assign auto_en = auto_q;

    // R8: the shadow changes only on a store copy
    a_r8_shadow_kept: assert property (@(posedge clk) disable iff (rst)
        !xfer.copy |=> $stable(sh_q[0]));
    // R10: the stored auto-store flag changes only on a store copy
    a_r10_auto_nv_kept: assert property (@(posedge clk) disable iff (rst)
        !xfer.copy |=> $stable(auto_sh));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned T_DLY = 4,
    parameter int unsigned T_ST  = 64,
    parameter int unsigned T_HI  = 4,
    parameter int unsigned T_LZ  = 8,
    parameter int unsigned T_RCL = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_req,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic          acc_ok,
    input  logic          sw_store,
    input  logic          sw_recall,
    input  logic          sw_auto_wr,
    input  logic          sw_auto_val,
    input  logic          supply_ok,
    input  logic          busy_pin_i,
    output logic          busy_drv_lo,
    output logic          busy_drv_hi,
    output logic          op_done,
    output logic [2:0]    op_state
);
    nvs_state_e st;
    nvs_xfer_t  xfer;
    logic       access_ok, auto_en, wr_acc, rd_acc;

    assign acc_ok   = acc_req & access_ok;
    assign wr_acc   = acc_ok & acc_we;
    assign rd_acc   = acc_ok & ~acc_we;
    assign op_state = st;

    nvs_seq #(
        .T_DLY(T_DLY), .T_ST(T_ST), .T_HI(T_HI), .T_LZ(T_LZ), .T_RCL(T_RCL)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .supply_ok (supply_ok),
        .pin_i     (busy_pin_i),
        .wr_acc    (wr_acc),
        .auto_en   (auto_en),
        .st        (st),
        .xfer      (xfer),
        .drv_lo    (busy_drv_lo),
        .drv_hi    (busy_drv_hi),
        .done      (op_done),
        .access_ok (access_ok)
    );

    nvs_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .wr_en    (wr_acc),
        .rd_en    (rd_acc),
        .addr     (acc_addr),
        .wdata    (acc_wdata),
        .auto_wr  (sw_auto_wr & access_ok),
        .auto_val (sw_auto_val),
        .rdata    (acc_rdata),
        .auto_en  (auto_en)
    );

    // R11: no access while the supply is low
    a_r11_supply_low_blocks: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !acc_ok);
    // R6: no access while the line is low
    a_r6_line_low_blocks: assert property (@(posedge clk) disable iff (rst)
        !busy_pin_i |-> !acc_ok);
endmodule

// File: tb/tb_nvs_ctrl.sv
module tb_nvs_ctrl;
    localparam int DW = 8, DEPTH = 16, AW = 4;
    localparam int T_DLY = 3, T_ST = 5, T_HI = 2, T_LZ = 3, T_RCL = 4;

    logic clk = 0, rst = 1;
    logic acc_req = 0, acc_we = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0, acc_rdata;
    logic acc_ok, sw_store = 0, sw_recall = 0, sw_auto_wr = 0, sw_auto_val = 0;
    logic supply_ok = 0, ext_low = 0, pin, busy_drv_lo, busy_drv_hi, op_done;
    logic [2:0] op_state;

    int checks = 0, fails = 0;
    int dur[8];
    int nlo, nhi, ndone, nacc;

    always #4 clk = ~clk;
    assign pin = ~(busy_drv_lo | ext_low);

    nvs_ctrl #(.DW(DW), .DEPTH(DEPTH), .T_DLY(T_DLY), .T_ST(T_ST), .T_HI(T_HI),
               .T_LZ(T_LZ), .T_RCL(T_RCL)) dut (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_ok(acc_ok),
        .sw_store(sw_store), .sw_recall(sw_recall), .sw_auto_wr(sw_auto_wr),
        .sw_auto_val(sw_auto_val), .supply_ok(supply_ok), .busy_pin_i(pin),
        .busy_drv_lo(busy_drv_lo), .busy_drv_hi(busy_drv_hi), .op_done(op_done),
        .op_state(op_state));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pat_a(input int a); return (a * 7 + 3) & 8'hFF; endfunction
    function automatic int pat_b(input int a); return (a * 13 + 200) & 8'hFF; endfunction

    task automatic wr(input int a, input int d);
        acc_req = 1; acc_we = 1; acc_addr = AW'(a); acc_wdata = DW'(d);
        @(negedge clk);
        acc_req = 0; acc_we = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        acc_req = 1; acc_we = 0; acc_addr = AW'(a);
        @(negedge clk);
        chk(acc_rdata == DW'(exp), tag, int'(acc_rdata), exp);
        acc_req = 0;
    endtask

    // pulses set at a negedge are dropped just after the next posedge
    task automatic fire;
        @(posedge clk); #1;
        sw_store = 0; sw_recall = 0; sw_auto_wr = 0; ext_low = 0;
    endtask

    task automatic op_watch;
        bit started = 0;
        for (int i = 0; i < 8; i++) dur[i] = 0;
        nlo = 0; nhi = 0; ndone = 0; nacc = 0;
        acc_req = 1; acc_we = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (op_state != 3'd0) begin
                started = 1;
                dur[op_state]++;
                nlo += int'(busy_drv_lo); nhi += int'(busy_drv_hi);
                ndone += int'(op_done); nacc += int'(acc_ok);
            end else if (started) break;
        end
        acc_req = 0;
    endtask

    task automatic chk_op(input string tag, input int d1, input int d2, input int d3,
                          input int d4, input int d5);
        chk(dur[1] == d1, {tag, " grace cycles"}, dur[1], d1);
        chk(dur[2] == d2, {tag, " store cycles"}, dur[2], d2);
        chk(dur[3] == d3, {tag, " release cycles R4"}, dur[3], d3);
        chk(dur[4] == d4, {tag, " lockout cycles R5"}, dur[4], d4);
        chk(dur[5] == d5, {tag, " recall cycles"}, dur[5], d5);
        chk(nlo == d1 + d2 + d5, {tag, " drive-low cycles R4"}, nlo, d1 + d2 + d5);
        chk(nhi == d3, {tag, " drive-high cycles R4"}, nhi, d3);
        chk(ndone == 1, {tag, " done pulses R5"}, ndone, 1);
        chk(nacc == 0, {tag, " access during op R5"}, nacc, 0);
    endtask

    task automatic idle_watch(input int n, input string tag);
        acc_req = 1; acc_we = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(op_state == 3'd0 && !busy_drv_lo, tag, int'(op_state), 0);
        end
        acc_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        acc_req = 1;
        @(negedge clk);
        chk(op_state == 3'd0, "R1 reset state idle", int'(op_state), 0);
        chk(!busy_drv_lo && !busy_drv_hi, "R4 reset no drive", int'(busy_drv_lo), 0);
        chk(!acc_ok, "R11 access blocked with supply low", int'(acc_ok), 0);
        acc_req = 0;

        // R7: power-up recall once supply is good
        supply_ok = 1; fire; op_watch;
        chk_op("R7 power-up recall", 0, 0, 0, T_LZ, T_RCL);
        for (int a = 0; a < DEPTH; a++) rd(a, 0, "R8 recall loads empty shadow");

        // R6: line held low with a clean array
        ext_low = 1;
        acc_req = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(op_state == 3'd0 && !busy_drv_lo && !acc_ok, "R6 clean line low",
                int'({op_state, busy_drv_lo, acc_ok}), 0);
        end
        ext_low = 0; acc_req = 0;
        @(negedge clk);

        // R1: full sweep of writes and read-back
        for (int a = 0; a < DEPTH; a++) wr(a, pat_a(a));
        for (int a = 0; a < DEPTH; a++) rd(a, pat_a(a), "R1 read-back pattern A");

        // R2: hardware store through the line
        ext_low = 1; fire; op_watch;
        chk_op("R2 line store", T_DLY, T_ST, T_HI, T_LZ, 0);

        // R13: clean after store, line request ignored
        ext_low = 1; fire; ext_low = 1; idle_watch(5, "R13 clean after store");
        ext_low = 0; @(negedge clk);

        // R8: overwrite, recall, expect stored pattern
        for (int a = 0; a < DEPTH; a++) wr(a, pat_b(a));
        for (int a = 0; a < DEPTH; a++) rd(a, pat_b(a), "R1 read-back pattern B");
        sw_recall = 1; fire; op_watch;
        chk_op("R8 software recall", 0, 0, 0, T_LZ, T_RCL);
        for (int a = 0; a < DEPTH; a++) rd(a, pat_a(a), "R8 recall restores pattern A");

        // R3: software store on a clean array runs with no grace
        sw_store = 1; fire; op_watch;
        chk_op("R3 software store clean", 0, T_ST, T_HI, T_LZ, 0);

        // R9: supply-drop store
        wr(0, 8'h5A);
        supply_ok = 0; fire; op_watch;
        chk_op("R9 supply-drop store", T_DLY, T_ST, T_HI, T_LZ, 0);
        acc_req = 1; @(negedge clk);
        chk(!acc_ok, "R11 blocked while supply low", int'(acc_ok), 0);
        acc_req = 0;
        supply_ok = 1; fire; op_watch;
        chk_op("R7 recall on supply rise", 0, 0, 0, T_LZ, T_RCL);
        rd(0, 8'h5A, "R9 supply-drop store kept data");

        // R10: disable without store does not persist
        sw_auto_wr = 1; sw_auto_val = 0; fire;
        @(negedge clk);
        wr(0, 8'hC3);
        supply_ok = 0; idle_watch(6, "R9 auto-store disabled");
        supply_ok = 1; fire; op_watch;
        chk_op("R7 recall after ignored drop", 0, 0, 0, T_LZ, T_RCL);
        rd(0, 8'h5A, "R10 unstored write lost");
        wr(0, 8'h77);
        supply_ok = 0; fire; op_watch;
        chk(dur[2] == T_ST, "R10 flag restored by recall, store runs", dur[2], T_ST);
        supply_ok = 1; fire; op_watch;
        rd(0, 8'h77, "R10 store after restore");

        // R10: disable followed by software store persists
        sw_auto_wr = 1; sw_auto_val = 0; fire;
        @(negedge clk);
        sw_store = 1; fire; op_watch;
        sw_recall = 1; fire; op_watch;
        wr(0, 8'h11);
        supply_ok = 0; idle_watch(6, "R10 disabled flag persisted");
        supply_ok = 1; fire; op_watch;
        rd(0, 8'h77, "R10 no store while persisted off");

        // R12: recall start and software store in the same cycle
        supply_ok = 0; repeat (2) @(negedge clk);
        supply_ok = 1; sw_store = 1; fire; op_watch;
        chk_op("R12 recall wins", 0, 0, 0, T_LZ, T_RCL);
        idle_watch(4, "R12 store dropped");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule